// File: doc/BRIEF.md
# TDM Serial Input Frame Aligner

This block takes sixteen serial time-division-multiplexed input lanes that share one clock and one frame pulse, and turns each lane into a stream of 8-bit channel bytes. Each byte comes with a one-cycle valid strobe and the number of the channel it belongs to. The clock runs at twice the serial bit rate, so every bit cell lasts two clock periods. A frame holds 32 channels.

Software sets up each lane on its own through four 16-bit registers. Each lane has a frame-start delay, counted in clock periods after the shared frame pulse, and a capture-edge select. A global mode input chooses between two framing conventions. The conventions differ in bit order within a channel and in what the capture-edge select means. A lane picks up new settings and a new mode only at its own delayed frame start, so no frame is ever assembled with a mix of settings.

Top module: `tdm_frame_aligner`

## Requirements
- R1: After reset, every configuration register reads 0000h, every lane has delay 0 and edge select 0, and no valid strobe is raised.
- R2: The configuration registers are at word addresses 3, 4, 5 and 6 and cover lanes 0-3, 4-7, 8-11 and 12-15. Within a register, lane 4k+j (j = 0..3) takes its delay code from bits [4j+3:4j+1], MSB first, and its edge select from bit 4j. Writes are visible on the read port at once. Writes to any other address are ignored, and reads from any other address return 0.
- R3: A lane whose delay is d restarts its frame d clock periods after the clock edge that samples `frame_pulse` high. Bit k of the frame covers the 2k-th and (2k+1)-th periods after that restart. Byte c is presented with a one-cycle `rx_valid` strobe in the period that follows the edge ending period 16c+15.
- R4: Delay codes 5, 6 and 7 act exactly like code 4.
- R5: With `mode_gci` = 0, the first bit of a channel is the byte's MSB. With `mode_gci` = 1, it is the byte's LSB.
- R6: The effective capture edge is the edge select XOR `mode_gci`. A value of 0 samples the lane at the rising edge that starts the cell's second period (the 1/2 point). A value of 1 samples it at the falling edge in the middle of that period (the 3/4 point).
- R7: The channel number counts 0 to 31 within a frame and goes back to 0 at each delayed frame start.
- R8: Register writes and `mode_gci` changes have no effect on a lane until its next delayed frame start.
- R9: A lane gives no valid strobe until its first delayed frame start after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the serial bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_gci | input | 1 | Framing mode: 0 MSB-first, 1 LSB-first with inverted edge sense |
| frame_pulse | input | 1 | Shared frame pulse, high for one clock period |
| sdata | input | 16 | Serial data, one bit per lane |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wr_data | input | 16 | Register write data |
| reg_rd_data | output | 16 | Register read data for `reg_addr` |
| rx_byte | output | 128 | Assembled byte per lane, lane n in bits [8n+7:8n] |
| rx_valid | output | 16 | Byte strobe per lane |
| rx_chan | output | 80 | Channel number per lane, lane n in bits [5n+4:5n] |

## Verification
The bench builds the block with its default parameters: 16 lanes, 32 channels of 8 bits, 16-bit registers based at address 3. This gives full 512-period frames and all four configuration words. Every delay from 0 to 4 and the clamped codes 5 to 7 appear side by side in one frame, so lanes with different restart points are compared against each other on every cycle. Because every lane has its own delay and edge field, one run covers every bit position of every register word, and both framing modes with both edge senses.

// File: rtl/tfa_pkg.sv
// Shared types and helpers for the TDM frame aligner.
// Assumes a lane setting is a delay code plus one edge-select bit.
package tfa_pkg;

    localparam int OFF_W     = 3;          // width of a lane delay code
    localparam int FIELD_W   = OFF_W + 1;  // delay code plus edge select
    localparam int MAX_SHIFT = 4;          // largest supported delay in periods

    typedef struct packed {
        logic [OFF_W-1:0] shift;
        logic             late_edge;
    } lane_cfg_t;

    typedef enum logic {
        FRM_MSB_FIRST = 1'b0,
        FRM_LSB_FIRST = 1'b1
    } frame_mode_t;

    // Limit a delay code to the supported range.
    function automatic logic [OFF_W-1:0] clamp_shift(input logic [OFF_W-1:0] code);
        return (code > OFF_W'(MAX_SHIFT)) ? OFF_W'(MAX_SHIFT) : code;
    endfunction

endpackage

// File: rtl/tfa_cfg_regs.sv
// Configuration register file for the frame aligner.
// Holds N_REGS words starting at BASE_ADDR. Each word carries the settings of
// DATA_W/FIELD_W lanes, with the edge select in the low bit of each field.
// Assumes N_LANES is a multiple of the lanes per word.
module tfa_cfg_regs
    import tfa_pkg::*;
#(
    parameter int N_LANES   = 16,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 4,
    parameter int BASE_ADDR = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [DATA_W-1:0]               wr_data,
    output logic [DATA_W-1:0]               rd_data,
    output lane_cfg_t [N_LANES-1:0]         cfg
);

    localparam int LANES_PER_REG = DATA_W / FIELD_W;
    localparam int N_REGS        = N_LANES / LANES_PER_REG;
    localparam int IDX_W         = (N_REGS > 1) ? $clog2(N_REGS) : 1;

    logic [N_REGS-1:0][DATA_W-1:0] regs;
    logic                          hit;
    logic [ADDR_W-1:0]             rel;
    logic [IDX_W-1:0]              idx;

    // Decode the address window.
    always_comb begin
        hit = (addr >= ADDR_W'(BASE_ADDR)) && (addr < ADDR_W'(BASE_ADDR + N_REGS));
        rel = addr - ADDR_W'(BASE_ADDR);
        idx = rel[IDX_W-1:0];
    end

    // Store register writes that land inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs <= '0;
        end else if (wr_en && hit) begin
            regs[idx] <= wr_data;
        end
    end

    // Return the addressed word, or zero outside the window.
    always_comb begin
        rd_data = hit ? regs[idx] : '0;
    end

    // Slice each word into per-lane settings.
    for (genvar l = 0; l < N_LANES; l++) begin : g_lane
        localparam int R = l / LANES_PER_REG;
        localparam int J = l % LANES_PER_REG;
        assign cfg[l].shift     = regs[R][FIELD_W*J+1 +: OFF_W];
        assign cfg[l].late_edge = regs[R][FIELD_W*J];
    end

    // R2: a write outside the window leaves every word untouched.
    a_r2_stray_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit) |=> $stable(regs));

    // R1: a reset cycle leaves all words cleared.
    a_r1_regs_cleared: assert property (@(posedge clk)
        !rst_n |=> (regs == '0));

endmodule

// File: rtl/tfa_fp_delay.sv
// Frame pulse tap line shared by every lane.
// Tap k is high in the cycle that is k clock periods after the pulse was
// sampled, and tap 0 is the live input. Assumes the pulse is one period wide.
module tfa_fp_delay #(
    parameter int MAX_SHIFT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_pulse,
    output logic [MAX_SHIFT:0] fp_tap
);

    logic [MAX_SHIFT-1:0] hist;

    // Shift the pulse history by one period each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else begin
            hist <= {hist[MAX_SHIFT-2:0], frame_pulse};
        end
    end

    assign fp_tap = {hist, frame_pulse};

    // R3: a sampled pulse shows up on the one-period tap.
    a_r3_tap_follows_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> fp_tap[1]);

endmodule

// File: rtl/tfa_lane_rx.sv
// Receiver for one serial lane.
// Waits for its delayed frame start, then takes one bit every two periods from
// either the rising-edge sample (1/2 point) or the falling-edge sample (3/4
// point). It assembles BITS-wide bytes in the order set by the framing mode
// and strobes each byte with its channel number. Settings are latched only at
// the frame start. Assumes BITS and N_CH are powers of two.
module tfa_lane_rx
    import tfa_pkg::*;
#(
    parameter int BITS = 8,
    parameter int N_CH = 32,
    localparam int CH_W  = $clog2(N_CH),
    localparam int BIT_W = $clog2(BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sdata,
    input  logic                 mode_gci,
    input  lane_cfg_t            cfg_next,
    input  logic [MAX_SHIFT:0]   fp_tap,
    output logic [BITS-1:0]      byte_q,
    output logic                 valid,
    output logic [CH_W-1:0]      chan
);

    localparam int POS_W = CH_W + BIT_W + 1;

    logic [OFF_W-1:0] act_shift;
    logic             act_late;
    frame_mode_t      act_mode;
    logic             synced;
    logic [POS_W-1:0] pos;
    logic             rise_q;
    logic             fall_q;
    logic             start;
    logic             bit_in;
    logic             take;
    logic             last;
    logic [BITS-1:0]  sh;
    logic [BITS-1:0]  sh_next;

    // Capture the lane at every falling edge (3/4 point candidate).
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            fall_q <= 1'b0;
        end else begin
            fall_q <= sdata;
        end
    end

    // Capture the lane at every rising edge (1/2 point candidate).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_q <= 1'b0;
        end else begin
            rise_q <= sdata;
        end
    end

    // Pick the delayed start, the capture source and the byte-complete point.
    always_comb begin
        start  = fp_tap[act_shift];
        bit_in = (act_late ^ (act_mode == FRM_LSB_FIRST)) ? fall_q : rise_q;
        take   = synced && pos[0];
        last   = take && (&pos[BIT_W:1]);
        if (act_mode == FRM_LSB_FIRST) begin
            sh_next = {bit_in, sh[BITS-1:1]};
        end else begin
            sh_next = {sh[BITS-2:0], bit_in};
        end
    end

    // Latch settings at the frame start and track the position in the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_shift <= '0;
            act_late  <= 1'b0;
            act_mode  <= FRM_MSB_FIRST;
            synced    <= 1'b0;
            pos       <= '0;
        end else if (start) begin
            act_shift <= clamp_shift(cfg_next.shift);
            act_late  <= cfg_next.late_edge;
            act_mode  <= frame_mode_t'(mode_gci);
            synced    <= 1'b1;
            pos       <= '0;
        end else if (synced) begin
            pos <= pos + POS_W'(1);
        end
    end

    // Shift in one bit per cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (take) begin
            sh <= sh_next;
        end
    end

    // Present each finished byte with its channel number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
            chan   <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= last;
            if (last) begin
                byte_q <= sh_next;
                chan   <= pos[POS_W-1 -: CH_W];
            end
        end
    end

    // R3: a byte strobe lasts exactly one period.
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R9: no byte before the first delayed frame start.
    a_r9_quiet_before_sync: assert property (@(posedge clk) disable iff (!rst_n)
        !synced |=> !valid);

    // R8: latched settings change only at a frame start.
    a_r8_settings_held: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable({act_shift, act_late, act_mode}));

    // R4: the latched delay never exceeds the supported range.
    a_r4_shift_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(synced) |-> (act_shift <= OFF_W'(MAX_SHIFT)));

endmodule

// File: rtl/tdm_frame_aligner.sv
// Top of the TDM serial input frame aligner.
// Joins the register file, the shared frame pulse tap line and one receiver
// per lane. Assumes one clock at twice the bit rate for all lanes.
module tdm_frame_aligner
    import tfa_pkg::*;
#(
    parameter int N_STREAMS    = 16,
    parameter int CH_PER_FRAME = 32,
    parameter int BITS_PER_CH  = 8,
    parameter int REG_W        = 16,
    parameter int ADDR_W       = 4,
    parameter int REG_BASE     = 3,
    localparam int CH_W        = $clog2(CH_PER_FRAME)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            mode_gci,
    input  logic                            frame_pulse,
    input  logic [N_STREAMS-1:0]            sdata,
    input  logic                            reg_wr_en,
    input  logic [ADDR_W-1:0]               reg_addr,
    input  logic [REG_W-1:0]                reg_wr_data,
    output logic [REG_W-1:0]                reg_rd_data,
    output logic [N_STREAMS*BITS_PER_CH-1:0] rx_byte,
    output logic [N_STREAMS-1:0]            rx_valid,
    output logic [N_STREAMS*CH_W-1:0]       rx_chan
);

    lane_cfg_t [N_STREAMS-1:0] lane_cfg;
    logic [MAX_SHIFT:0]        fp_tap;

    tfa_cfg_regs #(
        .N_LANES   (N_STREAMS),
        .DATA_W    (REG_W),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (REG_BASE)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .wr_data (reg_wr_data),
        .rd_data (reg_rd_data),
        .cfg     (lane_cfg)
    );

    tfa_fp_delay #(
        .MAX_SHIFT (MAX_SHIFT)
    ) u_fp (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_pulse (frame_pulse),
        .fp_tap      (fp_tap)
    );

    for (genvar s = 0; s < N_STREAMS; s++) begin : g_rx
        tfa_lane_rx #(
            .BITS (BITS_PER_CH),
            .N_CH (CH_PER_FRAME)
        ) u_rx (
            .clk      (clk),
            .rst_n    (rst_n),
            .sdata    (sdata[s]),
            .mode_gci (mode_gci),
            .cfg_next (lane_cfg[s]),
            .fp_tap   (fp_tap),
            .byte_q   (rx_byte[s*BITS_PER_CH +: BITS_PER_CH]),
            .valid    (rx_valid[s]),
            .chan     (rx_chan[s*CH_W +: CH_W])
        );
    end

    // R1: a reset cycle leaves every strobe low.
    a_r1_no_strobe_after_reset: assert property (@(posedge clk)
        !rst_n |=> (rx_valid == '0));

endmodule

// File: tb/tdm_frame_aligner_tb.sv
`timescale 1ns/1ps
module tdm_frame_aligner_tb;

    localparam int NS    = 16;
    localparam int NCH   = 32;
    localparam int FRAME = 512;
    localparam int CW    = 5;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            mode_gci;
    logic            frame_pulse;
    logic [NS-1:0]   sdata;
    logic            reg_wr_en;
    logic [3:0]      reg_addr;
    logic [15:0]     reg_wr_data;
    logic [15:0]     reg_rd_data;
    logic [NS*8-1:0] rx_byte;
    logic [NS-1:0]   rx_valid;
    logic [NS*CW-1:0] rx_chan;

    always #4 clk = ~clk;

    tdm_frame_aligner u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_gci    (mode_gci),
        .frame_pulse (frame_pulse),
        .sdata       (sdata),
        .reg_wr_en   (reg_wr_en),
        .reg_addr    (reg_addr),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data),
        .rx_byte     (rx_byte),
        .rx_valid    (rx_valid),
        .rx_chan     (rx_chan)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    int    strobes_seen = 0;

    // Reference model state, built from the requirements.
    int shadow  [4];
    int act_off [NS];
    bit act_late[NS];
    bit act_gci [NS];
    bit act_gl  [NS];
    bit m_sync  [NS];
    bit glitch  [NS];
    int mpos    [NS];
    int fnum    [NS];
    bit mode_m  = 1'b0;
    bit fp_drv  = 1'b0;
    bit fp_req  = 1'b0;
    bit fp_auto = 1'b0;
    bit fp_seen = 1'b0;
    int fp_cyc  = 0;
    int edge_idx = 0;

    function automatic logic [7:0] gen(int s, int f, int ch);
        int v;
        v = s * 53 + f * 29 + ch * 71 + 11;
        return 8'(v) ^ 8'(v >> 5);
    endfunction

    function automatic int eff(int code);
        return (code > 4) ? 4 : code;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One clock edge: compare outputs with the model, advance it, drive inputs.
    task automatic step();
        @(posedge clk);
        edge_idx++;
        #1;
        if (fp_drv) begin
            fp_cyc  = edge_idx;
            fp_seen = 1'b1;
        end
        for (int s = 0; s < NS; s++) begin
            int       oldpos;
            bit       exp_v;
            int       ech;
            logic [7:0] eb;
            oldpos = mpos[s];
            exp_v  = m_sync[s] && (oldpos % 16 == 15);
            ech    = oldpos / 16;
            eb     = gen(s, fnum[s], ech);
            if (act_gl[s] && (act_late[s] ^ act_gci[s])) eb = ~eb;
            if (rx_valid[s]) strobes_seen++;
            check(rx_valid[s] == exp_v, cur_req, $sformatf("lane %0d valid", s),
                  int'(rx_valid[s]), int'(exp_v));
            if (exp_v && rx_valid[s]) begin
                check(rx_byte[s*8 +: 8] == eb, cur_req, $sformatf("lane %0d byte", s),
                      int'(rx_byte[s*8 +: 8]), int'(eb));
                check(int'(rx_chan[s*CW +: CW]) == ech, cur_req,
                      $sformatf("lane %0d channel", s), int'(rx_chan[s*CW +: CW]), ech);
            end
            if (rst_n && fp_seen && edge_idx == fp_cyc + eff(act_off[s])) begin
                act_off[s]  = (shadow[s/4] >> (4*(s%4)+1)) & 7;
                act_late[s] = (shadow[s/4] >> (4*(s%4))) & 1;
                act_gci[s]  = mode_m;
                act_gl[s]   = glitch[s];
                m_sync[s]   = 1'b1;
                mpos[s]     = 0;
                fnum[s]++;
            end else if (m_sync[s]) begin
                mpos[s] = (mpos[s] + 1) % FRAME;
            end
        end
        if (rst_n && reg_wr_en && reg_addr >= 3 && reg_addr <= 6)
            shadow[reg_addr-3] = int'(reg_wr_data);
        fp_drv = fp_req || (fp_auto && fp_seen && (edge_idx - fp_cyc == FRAME - 1));
        fp_req = 1'b0;
        frame_pulse = fp_drv;
        mode_gci = mode_m;
        for (int s = 0; s < NS; s++) begin
            int p;
            int k;
            logic [7:0] bv;
            logic b;
            if (!m_sync[s]) begin
                sdata[s] = 1'b0;
            end else begin
                p  = mpos[s];
                k  = p / 2;
                bv = gen(s, fnum[s], k / 8);
                b  = act_gci[s] ? bv[k % 8] : bv[7 - (k % 8)];
                if (act_gl[s] && (p % 2 == 1)) b = ~b;
                sdata[s] = b;
            end
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic reg_write(int addr, int data);
        reg_addr    = 4'(addr);
        reg_wr_data = 16'(data);
        reg_wr_en   = 1'b1;
        step();
        reg_wr_en   = 1'b0;
    endtask

    task automatic set_lane(int s, int off, int late);
        int w;
        w = shadow[s/4];
        w = w & ~(32'hF << (4*(s%4)));
        w = w | (((off & 7) << 1 | (late & 1)) << (4*(s%4)));
        reg_write(3 + s/4, w);
    endtask

    task automatic t_reset();
        cur_req = "R1";
        for (int a = 3; a <= 6; a++) begin
            reg_addr = 4'(a);
            #1;
            check(reg_rd_data == 16'h0000, "R1", $sformatf("reg %0d after reset", a),
                  int'(reg_rd_data), 0);
        end
        check(rx_valid == '0, "R1", "strobes after reset", int'(rx_valid), 0);
    endtask

    task automatic t_quiet();
        cur_req = "R9";
        strobes_seen = 0;
        run(600);
        check(strobes_seen == 0, "R9", "strobes before any frame pulse", strobes_seen, 0);
    endtask

    task automatic t_regmap();
        int pat[4] = '{16'h1A2B, 16'h3C4D, 16'h5E6F, 16'h7081};
        cur_req = "R2";
        for (int r = 0; r < 4; r++) reg_write(3 + r, pat[r]);
        for (int r = 0; r < 4; r++) begin
            reg_addr = 4'(3 + r);
            #1;
            check(int'(reg_rd_data) == pat[r], "R2", $sformatf("readback reg %0d", 3 + r),
                  int'(reg_rd_data), pat[r]);
        end
        reg_write(2, 16'hFFFF);
        reg_write(7, 16'hFFFF);
        for (int r = 0; r < 4; r++) begin
            reg_addr = 4'(3 + r);
            #1;
            check(int'(reg_rd_data) == pat[r], "R2", $sformatf("reg %0d after stray write", 3 + r),
                  int'(reg_rd_data), pat[r]);
        end
        reg_addr = 4'd7;
        #1;
        check(reg_rd_data == 16'h0000, "R2", "read outside window", int'(reg_rd_data), 0);
        set_lane(5, 3, 1);
        reg_addr = 4'd4;
        #1;
        check(reg_rd_data[7:4] == 4'b0111, "R2", "lane 5 field placement",
              int'(reg_rd_data[7:4]), 7);
        for (int r = 0; r < 4; r++) reg_write(3 + r, 0);
    endtask

    task automatic t_offsets();
        cur_req = "R3";
        for (int s = 0; s < NS; s++) set_lane(s, s % 5, 0);
        fp_req  = 1'b1;
        fp_auto = 1'b1;
        run(FRAME * 2);
        cur_req = "R7";
        run(FRAME);
    endtask

    task automatic t_clamp();
        cur_req = "R4";
        for (int s = 0; s < NS; s++) set_lane(s, 4 + (s % 4), 0);
        run(FRAME * 2);
    endtask

    task automatic t_gci();
        cur_req = "R5";
        mode_m = 1'b1;
        run(FRAME * 2);
        mode_m = 1'b0;
        run(FRAME * 2);
    endtask

    task automatic t_edges();
        cur_req = "R6";
        for (int s = 0; s < NS; s++) begin
            glitch[s] = 1'b1;
            set_lane(s, s % 5, s % 2);
        end
        run(FRAME * 2);
        mode_m = 1'b1;
        run(FRAME * 2);
        mode_m = 1'b0;
        run(FRAME * 2);
    endtask

    task automatic t_midframe();
        cur_req = "R8";
        run(200);
        for (int s = 0; s < NS; s++) set_lane(s, 4 - (s % 5), (s + 1) % 2);
        mode_m = 1'b1;
        run(FRAME * 2);
        for (int s = 0; s < NS; s++) set_lane(s, (s * 3) % 8, s % 2);
        run(FRAME * 2);
    endtask

    initial begin
        rst_n       = 1'b0;
        mode_gci    = 1'b0;
        frame_pulse = 1'b0;
        sdata       = '0;
        reg_wr_en   = 1'b0;
        reg_addr    = '0;
        reg_wr_data = '0;
        for (int s = 0; s < NS; s++) begin
            act_off[s] = 0; act_late[s] = 0; act_gci[s] = 0; act_gl[s] = 0;
            m_sync[s] = 0; glitch[s] = 0; mpos[s] = 0; fnum[s] = 0;
        end
        for (int r = 0; r < 4; r++) shadow[r] = 0;
        run(4);
        rst_n = 1'b1;
        t_reset();
        t_quiet();
        t_regmap();
        t_offsets();
        t_clamp();
        t_gci();
        t_edges();
        t_midframe();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog %s actual=running expected=finished", cur_req);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule